// File: doc/BRIEF.md
# Drawing Command Queue with Status Word

This block sits between a host write port and a drawing back end. Each host command write names a target register by index and carries a 32-bit data word. The pair is stored in a fixed-depth first-in first-out queue, and the back end drains the queue one entry at a time whenever it signals ready. A write that arrives while the queue is full is not stalled. It is discarded, and a sticky error bit records the loss.

A single 32-bit status word is always visible to the host. It packs the following fields:
- the number of free queue slots;
- a frame-store busy flag taken from the back end;
- an engine busy flag that covers both pending commands and back-end activity;
- two sticky error bits, one for lost writes and one for illegal reads.

The host clears an error bit by writing a one to its position in the status word. Software keeps a safety margin of RESERVE slots, so the block also presents the usable slot count with that margin already subtracted.

Top module: `cmdq_frontend`

## Requirements
- R1: Status bits [11:0] always equal DEPTH minus the number of stored entries. After reset they read DEPTH.
- R2: `cons_valid` is high whenever the queue holds an entry. `cons_idx` and `cons_data` present the oldest entry. An entry is removed on a clock edge where `cons_valid` and `cons_ready` are both high. Entries leave in the order they were written, and a head entry that is not taken stays unchanged.
- R3: A command write (`host_wr`=1, `host_to_status`=0) made while the queue holds DEPTH entries is discarded and sets status bit 31. This holds even if an entry is removed on the same edge.
- R4: Status bit 31 stays set until a status write (`host_wr`=1, `host_to_status`=1) carries a one in data bit 31. A status write with data bit 31 at zero leaves the bit unchanged.
- R5: A pulse on `host_rd_cmd` sets status bit 30, which stays set until a status write carries a one in data bit 30.
- R6: When an error bit is set and cleared on the same edge, it ends up set.
- R7: Status bit 24 follows `cons_busy`. Status bit 25 is high when the queue is non-empty or `cons_busy` is high. Bits [23:12] and [29:26] read zero.
- R8: `usable_slots` equals the free count minus RESERVE, or zero when the free count is RESERVE or less.
- R9: A status write never enters the queue and does not change the free count.
- R10: The active-low synchronous reset empties the queue and clears both error bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_wr | input | 1 | Host write strobe |
| host_to_status | input | 1 | 1: the write targets the status word; 0: the write is a queued command |
| host_idx | input | IDX_W | Register index of a command write |
| host_wdata | input | DATA_W | Write data |
| host_rd_cmd | input | 1 | Host attempted to read a write-only command register |
| status_word | output | 32 | Free count, busy flags and error bits |
| usable_slots | output | 12 | Free count less the reserve, floored at zero |
| cons_valid | output | 1 | Head entry is available |
| cons_idx | output | IDX_W | Register index of the head entry |
| cons_data | output | DATA_W | Data word of the head entry |
| cons_ready | input | 1 | Back end takes the head entry on this edge |
| cons_busy | input | 1 | Back end is still working |

## Verification
Two cases collide in a single cycle, and both are driven on purpose.

- **Error set and clear together.** A command-register read pulse is driven together with a status write that clears the read-error bit. The bench expects the bit to read one afterwards.
- **Full queue, push and pop together.** A command write is driven into a full queue while the back end takes an entry on the same edge. The bench expects the write to be lost, the free count to read one, and the overflow bit to be set.

A behavioural queue model tracks every field on every cycle. Long random runs then mix these collisions with ordinary traffic.

// File: rtl/cmdq_pkg.sv
// Shared bit positions of the command queue status word.
package cmdq_pkg;
    localparam int STAT_W      = 32;
    localparam int FREE_W      = 12;
    localparam int BIT_FB_BUSY = 24;
    localparam int BIT_RP_BUSY = 25;
    localparam int BIT_RD_ERR  = 30;
    localparam int BIT_OVF     = 31;
    localparam int NUM_ERR     = 2;
    localparam int ERR_RD      = 0;
    localparam int ERR_OVF     = 1;
endpackage

// File: rtl/cmdq_fifo.sv
// Fixed-depth FIFO for command entries.
// Assumes: a push into a full queue is refused even when a pop happens on the
// same edge; a pop on an empty queue is ignored. Data slots are not reset.
module cmdq_fifo #(
    parameter int DEPTH   = 16,
    parameter int ENTRY_W = 40,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_req,
    input  logic [ENTRY_W-1:0] push_entry,
    input  logic               pop_req,
    output logic [ENTRY_W-1:0] head_entry,
    output logic               not_empty,
    output logic               full,
    output logic [CNT_W-1:0]   occupancy
);
    logic [PTR_W-1:0]   wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]   count_q;
    logic               push_ok, pop_ok;
    logic [ENTRY_W-1:0] slot_bus [DEPTH];

    assign not_empty  = (count_q != '0);
    assign full       = (count_q == CNT_W'(DEPTH));
    assign occupancy  = count_q;
    assign push_ok    = push_req && !full;
    assign pop_ok     = pop_req && not_empty;
    assign head_entry = slot_bus[rd_ptr_q];

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // One storage register per slot, loaded when the write pointer selects it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [ENTRY_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (push_ok && wr_ptr_q == PTR_W'(g)) slot_q <= push_entry;
        end
        assign slot_bus[g] = slot_q;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_ok) wr_ptr_q <= next_ptr(wr_ptr_q);
            if (pop_ok)  rd_ptr_q <= next_ptr(rd_ptr_q);
            case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CNT_W'(DEPTH));

    p_drop_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full) |=> occupancy <= $past(occupancy));

    p_head_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (not_empty && !pop_req) |=> (not_empty && $stable(head_entry)));
endmodule

// File: rtl/cmdq_errflags.sv
// Bank of sticky error flags with write-one-to-clear.
// Assumes: set and clear on the same edge leave the flag set.
module cmdq_errflags #(
    parameter int NUM = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] set_req,
    input  logic [NUM-1:0] clr_req,
    output logic [NUM-1:0] flag
);
    for (genvar g = 0; g < NUM; g++) begin : g_flag
        logic flag_q;

        // Sticky flag: set dominates clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          flag_q <= 1'b0;
            else if (set_req[g]) flag_q <= 1'b1;
            else if (clr_req[g]) flag_q <= 1'b0;
        end
        assign flag[g] = flag_q;

        p_sticky_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[g] && !clr_req[g]) |=> flag[g]);

        p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
            set_req[g] |=> flag[g]);
    end
endmodule

// File: rtl/cmdq_status.sv
// Assembles the host status word and the reserve-adjusted slot count.
// Assumes: DEPTH fits in the 12-bit free field.
module cmdq_status
    import cmdq_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int RESERVE = 8,
    parameter int CNT_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  occupancy,
    input  logic              not_empty,
    input  logic              cons_busy,
    input  logic              ovf_flag,
    input  logic              rderr_flag,
    output logic [STAT_W-1:0] status_word,
    output logic [FREE_W-1:0] usable_slots
);
    localparam logic [FREE_W-1:0] DEPTH_F = FREE_W'(DEPTH);
    localparam logic [FREE_W-1:0] RES_F   = FREE_W'(RESERVE);

    logic [FREE_W-1:0] free_cnt;

    assign free_cnt = DEPTH_F - FREE_W'(occupancy);

    // Pack fields into the status word.
    always_comb begin
        status_word                  = '0;
        status_word[FREE_W-1:0]      = free_cnt;
        status_word[BIT_FB_BUSY]     = cons_busy;
        status_word[BIT_RP_BUSY]     = not_empty || cons_busy;
        status_word[BIT_RD_ERR]      = rderr_flag;
        status_word[BIT_OVF]         = ovf_flag;
    end

    // Usable space after the host reserve, floored at zero.
    always_comb begin
        usable_slots = (free_cnt > RES_F) ? (free_cnt - RES_F) : '0;
    end

    p_usable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        usable_slots <= status_word[FREE_W-1:0]);
endmodule

// File: rtl/cmdq_frontend.sv
// Top of the drawing command queue: routes host writes into the FIFO or the
// status word, raises sticky errors and presents the head entry to the back end.
// Assumes: DATA_W >= 32 so that status writes carry the clear bits.
module cmdq_frontend
    import cmdq_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int IDX_W   = 8,
    parameter int DATA_W  = 32,
    parameter int RESERVE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_to_status,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd_cmd,
    output logic [31:0]       status_word,
    output logic [11:0]       usable_slots,
    output logic              cons_valid,
    output logic [IDX_W-1:0]  cons_idx,
    output logic [DATA_W-1:0] cons_data,
    input  logic              cons_ready,
    input  logic              cons_busy
);
    localparam int ENTRY_W = IDX_W + DATA_W;
    localparam int CNT_W   = $clog2(DEPTH + 1);

    logic               cmd_wr, stat_wr, fifo_full, fifo_ne;
    logic [ENTRY_W-1:0] head;
    logic [CNT_W-1:0]   occ;
    logic [NUM_ERR-1:0] err_set, err_clr, err_flag;

    assign cmd_wr  = host_wr && !host_to_status;
    assign stat_wr = host_wr && host_to_status;

    cmdq_fifo #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_req   (cmd_wr),
        .push_entry ({host_idx, host_wdata}),
        .pop_req    (cons_ready),
        .head_entry (head),
        .not_empty  (fifo_ne),
        .full       (fifo_full),
        .occupancy  (occ)
    );

    // Error sources and write-one-to-clear requests.
    always_comb begin
        err_set          = '0;
        err_clr          = '0;
        err_set[ERR_OVF] = cmd_wr && fifo_full;
        err_set[ERR_RD]  = host_rd_cmd;
        err_clr[ERR_OVF] = stat_wr && host_wdata[BIT_OVF];
        err_clr[ERR_RD]  = stat_wr && host_wdata[BIT_RD_ERR];
    end

    cmdq_errflags #(.NUM(NUM_ERR)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (err_set),
        .clr_req (err_clr),
        .flag    (err_flag)
    );

    cmdq_status #(.DEPTH(DEPTH), .RESERVE(RESERVE), .CNT_W(CNT_W)) u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .occupancy    (occ),
        .not_empty    (fifo_ne),
        .cons_busy    (cons_busy),
        .ovf_flag     (err_flag[ERR_OVF]),
        .rderr_flag   (err_flag[ERR_RD]),
        .status_word  (status_word),
        .usable_slots (usable_slots)
    );

    assign cons_valid = fifo_ne;
    assign cons_idx   = head[ENTRY_W-1:DATA_W];
    assign cons_data  = head[DATA_W-1:0];

    p_rp_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cons_valid |-> status_word[BIT_RP_BUSY]);

    p_stat_no_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !cons_ready) |=> status_word[11:0] == $past(status_word[11:0]));

    p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && fifo_full) |=> status_word[BIT_OVF]);
endmodule

// File: tb/tb_cmdq_frontend.sv
`timescale 1ns/1ps
module tb_cmdq_frontend;
    localparam int DEPTH   = 16;
    localparam int IDX_W   = 8;
    localparam int DATA_W  = 32;
    localparam int RESERVE = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_wr = 1'b0, host_to_status = 1'b0, host_rd_cmd = 1'b0;
    logic [IDX_W-1:0]  host_idx = '0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic              cons_ready = 1'b0, cons_busy = 1'b0;
    logic [31:0]       status_word;
    logic [11:0]       usable_slots;
    logic              cons_valid;
    logic [IDX_W-1:0]  cons_idx;
    logic [DATA_W-1:0] cons_data;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [IDX_W+DATA_W-1:0] mq[$];
    bit m_ovf = 0, m_rderr = 0;

    always #2.5 clk = ~clk;

    cmdq_frontend #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W), .RESERVE(RESERVE)) dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_to_status(host_to_status),
        .host_idx(host_idx), .host_wdata(host_wdata), .host_rd_cmd(host_rd_cmd),
        .status_word(status_word), .usable_slots(usable_slots), .cons_valid(cons_valid),
        .cons_idx(cons_idx), .cons_data(cons_data), .cons_ready(cons_ready), .cons_busy(cons_busy)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
        end
    endtask

    // Model of one clock edge, using the inputs now driven.
    task automatic model_edge();
        bit full, pop;
        if (!rst_n) begin
            mq.delete(); m_ovf = 0; m_rderr = 0;
        end else begin
            full = (mq.size() == DEPTH);
            pop  = cons_ready && (mq.size() != 0);
            if (host_wr && !host_to_status && full) m_ovf = 1;
            else if (host_wr && host_to_status && host_wdata[31]) m_ovf = 0;
            if (host_rd_cmd) m_rderr = 1;
            else if (host_wr && host_to_status && host_wdata[30]) m_rderr = 0;
            if (pop) void'(mq.pop_front());
            if (host_wr && !host_to_status && !full) mq.push_back({host_idx, host_wdata});
        end
    endtask

    task automatic compare_all();
        int free_n, use_n;
        logic [31:0] exp_st;
        free_n = DEPTH - mq.size();
        use_n  = (free_n > RESERVE) ? free_n - RESERVE : 0;
        exp_st = '0;
        exp_st[11:0] = 12'(free_n);
        exp_st[24] = cons_busy;
        exp_st[25] = (mq.size() != 0) || cons_busy;
        exp_st[30] = m_rderr;
        exp_st[31] = m_ovf;
        check("R1 free count", 64'(status_word[11:0]), 64'(exp_st[11:0]));
        check("R7 busy and zero bits", 64'(status_word[29:12]), 64'(exp_st[29:12]));
        check("R4 overflow bit", 64'(status_word[31]), 64'(exp_st[31]));
        check("R5 read error bit", 64'(status_word[30]), 64'(exp_st[30]));
        check("R8 usable slots", 64'(usable_slots), 64'(use_n));
        check("R2 valid", 64'(cons_valid), 64'(mq.size() != 0));
        if (mq.size() != 0)
            check("R2 head entry", 64'({cons_idx, cons_data}), 64'(mq[0]));
    endtask

    task automatic cyc(input bit wr, input bit to_st, input logic [IDX_W-1:0] idx,
                       input logic [DATA_W-1:0] d, input bit rdc, input bit rdy, input bit bsy);
        host_wr = wr; host_to_status = to_st; host_idx = idx; host_wdata = d;
        host_rd_cmd = rdc; cons_ready = rdy; cons_busy = bsy;
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // Reset
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        model_edge();
        rst_n = 1'b1;
        check("R10 reset status", 64'(status_word), 64'(32'h0000_0010));
        check("R10 reset valid", 64'(cons_valid), 64'd0);
        check("R10 reset usable", 64'(usable_slots), 64'd8);

        // Three pushes, held, then drained in order.
        for (int i = 0; i < 3; i++) cyc(1, 0, 8'(8'h10 + i), 32'hA000_0000 + i, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 1, 0);

        // Fill beyond capacity.
        for (int i = 0; i < DEPTH + 2; i++) cyc(1, 0, 8'(i), 32'hB000_0000 + i, 0, 0, 1);
        check("R3 overflow after full write", 64'(status_word[31]), 64'd1);
        check("R3 free zero when full", 64'(status_word[11:0]), 64'd0);

        // Clear, then push into a full queue while popping.
        cyc(1, 1, 0, 32'h8000_0000, 0, 0, 0);
        cyc(1, 0, 8'h77, 32'hDEAD_BEEF, 0, 1, 0);
        check("R3 write dropped with pop", 64'(status_word[11:0]), 64'd1);
        check("R3 overflow set with pop", 64'(status_word[31]), 64'd1);

        // Status write without bit 31: no clear, no push.
        cyc(1, 1, 8'h55, 32'h4000_0000, 0, 0, 0);
        check("R4 overflow kept", 64'(status_word[31]), 64'd1);
        check("R9 status write not queued", 64'(status_word[11:0]), 64'd1);
        cyc(1, 1, 0, 32'h8000_0000, 0, 0, 0);
        check("R4 overflow cleared", 64'(status_word[31]), 64'd0);

        // Read error set and clear.
        cyc(0, 0, 0, 0, 1, 0, 0);
        check("R5 read error set", 64'(status_word[30]), 64'd1);
        cyc(1, 1, 0, 32'h4000_0000, 0, 0, 0);
        check("R5 read error cleared", 64'(status_word[30]), 64'd0);
        cyc(1, 1, 0, 32'h4000_0000, 1, 0, 0);
        check("R6 set wins over clear", 64'(status_word[30]), 64'd1);
        cyc(1, 1, 0, 32'hC000_0000, 0, 0, 0);

        // Drain
        for (int i = 0; i < DEPTH + 2; i++) cyc(0, 0, 0, 0, 0, 1, 0);
        check("R1 empty after drain", 64'(status_word[11:0]), 64'd16);

        // Random traffic.
        for (int i = 0; i < 4000; i++) begin
            bit wr, st, rdc, rdy, bsy;
            wr  = ($urandom_range(0, 99) < 55);
            st  = ($urandom_range(0, 99) < 12);
            rdc = ($urandom_range(0, 99) < 4);
            rdy = ($urandom_range(0, 99) < ((i / 500) % 2 == 0 ? 30 : 70));
            bsy = $urandom_range(0, 1);
            cyc(wr, st, 8'($urandom), $urandom, rdc, rdy, bsy);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule